// File: doc/BRIEF.md
# Parity-Balanced Line Word Framer

This block is a single registered stage that sits right after the payload scrambler in a line transmitter. Each input is an 18-bit scrambled payload: two frame/check bits followed by sixteen data bits. The block turns it into a 20-bit line word by placing one parity slot after the first six payload bits and a second slot after the next six. The payload therefore falls into three six-bit groups, A, B and C, with a parity slot between each pair.

Every word leaves with an even count of ones. A word that starts on the neutral level of a three-level line code also ends on a neutral phase. When the payload already has even parity, both slots carry a one. When the payload parity is odd, exactly one slot is cleared. The slot that keeps its one is the one next to the sparser of the two outer groups, which adds a transition where the line would otherwise sit still longest.

Each word is handled on its own, with one cycle of latency and no backpressure. A separate parity checker watches the produced word and raises a flag if the word is ever odd.

Top module: `parity_framer`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released with no input, out_valid is 0, out_word is 0 and err_check is 0.
- R2: Bit placement, with the word sent from bit 19 first. out_word[19:14] = payload[17:12] (group A: frame bits 17:16, then four data bits). out_word[13] is slot P1. out_word[12:7] = payload[11:6] (group B). out_word[6] is slot P2. out_word[5:0] = payload[5:0] (group C).
- R3: If the payload has an even number of ones, P1 = 1 and P2 = 1.
- R4: If the payload has an odd number of ones, exactly one of P1 and P2 is 1, so every produced word has an even number of ones.
- R5: If the payload parity is odd and popcount(A) <= popcount(C), including a tie, then P1 = 1 and P2 = 0.
- R6: If the payload parity is odd and popcount(A) > popcount(C), then P1 = 0 and P2 = 1.
- R7: out_valid equals in_valid one cycle earlier. The word for a payload accepted at one rising edge appears after that edge, and back-to-back valid cycles produce back-to-back words.
- R8: In a cycle where in_valid is 0, out_word keeps its previous value.
- R9: err_check is 1 only when out_valid is 1 and out_word has an odd number of ones. For every word the framer produces, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Payload strobe |
| in_payload | input | 18 | Scrambled payload, bit 17 first |
| out_valid | output | 1 | Word strobe, one cycle after in_valid |
| out_word | output | 20 | Framed line word, bit 19 sent first |
| err_check | output | 1 | Odd parity seen on a valid output word |

## Verification
The bench targets odd payloads where groups A and C have equal popcounts. A design that breaks the tie the wrong way clears P1 instead of P2. It also uses strongly unequal groups, where a swapped comparison keeps the wrong slot. The all-zero and all-one payloads check that even parity leaves both slots set; a design that inverts the parity sense would clear a slot and produce an odd word. Back-to-back streams followed by idle cycles expose an off-by-one latency, a valid strobe that does not follow the input, and a word register that loads while in_valid is low.

// File: rtl/parity_framer.sv
module parity_framer #(
  parameter int GW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3*GW-1:0]   in_payload,
  output logic              out_valid,
  output logic [3*GW+1:0]   out_word,
  output logic              err_check
);
  localparam int PW = 3*GW;
  localparam int WW = PW + 2;
  localparam int CW = $clog2(GW+1);

  function automatic logic [CW-1:0] ones(input logic [GW-1:0] g);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < GW; i++) n = n + CW'(g[i]);
    return n;
  endfunction

  function automatic logic odd_word(input logic [WW-1:0] w);
    return ^w;
  endfunction

  logic [GW-1:0] grp_a, grp_b, grp_c;
  logic          pay_odd, keep_p1, p1, p2;

  assign grp_a   = in_payload[PW-1:2*GW];
  assign grp_b   = in_payload[2*GW-1:GW];
  assign grp_c   = in_payload[GW-1:0];
  assign pay_odd = ^in_payload;
  assign keep_p1 = ones(grp_a) <= ones(grp_c);
  assign p1      = !pay_odd || keep_p1;
  assign p2      = !pay_odd || !keep_p1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= {grp_a, p1, grp_b, p2, grp_c};
    end
  end

  assign err_check = out_valid && odd_word(out_word);
endmodule

// File: rtl/parity_framer_chk.sv
module parity_framer_chk #(
  parameter int GW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [3*GW-1:0] in_payload,
  input logic            out_valid,
  input logic [3*GW+1:0] out_word,
  input logic            err_check
);
  localparam int PW = 3*GW;
  localparam int P1B = 2*GW + 1;
  localparam int P2B = GW;

  // R2
  placement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[PW+1:P1B+1] == $past(in_payload[PW-1:2*GW])) &&
                 (out_word[P1B-1:P2B+1] == $past(in_payload[2*GW-1:GW])) &&
                 (out_word[GW-1:0] == $past(in_payload[GW-1:0])));

  // R3
  even_both_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(^in_payload)) |=> (out_word[P1B] && out_word[P2B]));

  // R4
  odd_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (^in_payload)) |=> ($countones({out_word[P1B], out_word[P2B]}) == 1));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(out_word));

  // R9
  no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !err_check);
endmodule

bind parity_framer parity_framer_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_payload(in_payload),
  .out_valid(out_valid), .out_word(out_word), .err_check(err_check)
);

// File: tb/parity_framer_tb.sv
`timescale 1ns/1ps
module parity_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [17:0] in_payload = '0;
  logic        out_valid;
  logic [19:0] out_word;
  logic        err_check;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  parity_framer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_payload(in_payload),
    .out_valid(out_valid), .out_word(out_word), .err_check(err_check)
  );

  function automatic logic [19:0] model(input logic [17:0] p);
    int na, nc, nt;
    logic s1, s2;
    na = $countones(p[17:12]);
    nc = $countones(p[5:0]);
    nt = $countones(p);
    if (nt % 2 == 0) begin s1 = 1; s2 = 1; end
    else if (na <= nc) begin s1 = 1; s2 = 0; end
    else begin s1 = 0; s2 = 1; end
    return {p[17:12], s1, p[11:6], s2, p[5:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [17:0] p);
    chk(req, {12'd0, out_word}, {12'd0, model(p)});
    chk({req, " valid R7"}, {31'd0, out_valid}, 32'd1);
    chk({req, " err R9"}, {31'd0, err_check}, 32'd0);
  endtask

  task automatic send(input string req, input logic [17:0] p);
    @(negedge clk); in_valid = 1; in_payload = p;
    @(negedge clk); in_valid = 0; in_payload = '0;
    check_word(req, p);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1 valid", {31'd0, out_valid}, 0);
    chk("R1 word", {12'd0, out_word}, 0);
    chk("R1 err", {31'd0, err_check}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle valid", {31'd0, out_valid}, 0);
    chk("R1 idle word", {12'd0, out_word}, 0);
  endtask

  task automatic t_even;
    send("R3 all zero", 18'h00000);
    chk("R3 slots zero", {30'd0, out_word[13], out_word[6]}, 32'd3);
    send("R3 all one", 18'h3FFFF);
    chk("R3 word all one", {12'd0, out_word}, 32'hFFFFF);
    send("R2 R3 mixed", 18'b10_1100_011010_001111);
  endtask

  task automatic t_odd;
    send("R5 A<C", 18'b000001_000000_000011);
    chk("R5 slots", {30'd0, out_word[13], out_word[6]}, 32'd2);
    send("R6 A>C", 18'b000111_000001_000001);
    chk("R6 slots", {30'd0, out_word[13], out_word[6]}, 32'd1);
    send("R5 tie", 18'b000011_000001_000011);
    chk("R5 tie slots", {30'd0, out_word[13], out_word[6]}, 32'd2);
    send("R4 single bit", 18'b000000_100000_000000);
    chk("R4 even word", {31'd0, ^out_word}, 0);
  endtask

  task automatic t_stream;
    logic [17:0] v [4] = '{18'h2A5C3, 18'h00001, 18'h3F000, 18'h1234F};
    @(negedge clk); in_valid = 1; in_payload = v[0];
    for (int i = 1; i < 4; i++) begin
      @(negedge clk); check_word("R7 stream", v[i-1]); in_payload = v[i];
    end
    @(negedge clk); in_valid = 0; in_payload = 18'h15555;
    check_word("R7 stream last", v[3]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 hold word", {12'd0, out_word}, {12'd0, model(v[3])});
      chk("R7 idle valid", {31'd0, out_valid}, 0);
      chk("R9 idle err", {31'd0, err_check}, 0);
    end
  endtask

  initial begin
    t_reset();
    t_even();
    t_odd();
    t_stream();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule